// File: doc/BRIEF.md
# Serial-Command to SPI Register Bridge

This block sits between a byte-wide UART interface and the SPI port of a 24-bit-register measurement converter. A host sends single-byte commands, some of them followed by argument bytes, and the bridge turns each command into the matching SPI transaction. The transactions are register writes, register reads, calibration starts, normal conversions, a serial-port resynchronisation pattern, a restore-defaults write and raw single-byte transfers. Any data that comes back from the converter is returned to the host as UART bytes.

The UART bit-level logic is outside this block. Incoming bytes arrive on a valid/ready pair and outgoing bytes leave on another. Every multi-byte value crosses the UART link low byte first. On the SPI side the bridge uses mode 0 (SCLK idles low, data is sampled on the rising edge) and sends the most significant bit first. Chip select stays low for a whole transaction.

Top module: `serlink_spi_bridge`

## Requirements
- R1: A write command (bit 7 = 0, bit 3 = 0, register code in bits 2:0) takes three more UART bytes, low byte first. The bridge then clocks 32 bits on SPI: the command byte, followed by the assembled 24-bit value.
- R2: A read command (bit 7 = 0, bit 3 = 1) clocks 32 bits on SPI: the command byte, then 24 bits captured from SDO. It returns three UART bytes, bits 7:0 first.
- R3: Register codes in bits 2:0 are 1 (offset) and 2 (gain) for any channel in bits 6:4, and 3 (configuration) and 5 (channel setup) only with channel field 0. Code 4 is the result FIFO, valid only as read 0x0C. Any other register-space byte is ignored.
- R4: A setup command with bit 7 = 1 and operation bits 2:0 of 1, 2, 5 or 6 (the calibrations) sends only its 8-bit command byte on SPI and returns no bytes.
- R5: A setup command with operation 0 (normal conversion) sends its 8-bit command byte and waits with CS held low until conv_ready is high. It then clocks 24 result bits and returns them as three bytes, low byte first.
- R6: If conv_ready does not arrive within TIMEOUT_CYC cycles, the bridge returns three 0x00 bytes and raises err_timeout. The flag stays high until the next command byte is accepted.
- R7: Command 0x3F drives 128 consecutive ones on SDI followed by one zero, in a single chip-select period.
- R8: Command 0x4F writes the configuration register (command 0x03) with the value RESET_CFG as a 32-bit transaction.
- R9: Command 0x1F takes one count byte N and runs N normal conversions on setup 1 (command 0x80), each in its own chip-select period, returning three bytes per conversion. A count of 0 does nothing.
- R10: Command 0xFF takes one byte and shifts it out on SDI as 8 bits. Command 0xEF clocks 8 bits from SDO and returns them as one byte.
- R11: An ignored command causes no SCLK edge, no chip-select activity and no returned byte, and the bridge accepts the next byte.
- R12: SCLK is low whenever CS is high, SDI does not change on a rising SCLK edge, and CS is high whenever the bridge can accept a UART byte.
- R13: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_byte holds its value. No UART byte is accepted while a byte is being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Incoming UART byte is present |
| rx_byte | input | 8 | Incoming UART byte |
| rx_ready | output | 1 | Bridge accepts rx_byte in this cycle |
| tx_valid | output | 1 | Outgoing byte is offered |
| tx_byte | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Transmitter takes tx_byte in this cycle |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_sdi | output | 1 | Serial data to the converter |
| spi_sdo | input | 1 | Serial data from the converter |
| conv_ready | input | 1 | Converter has a conversion result ready |
| err_timeout | output | 1 | Last conversion wait expired |

## Verification
The bench builds the bridge with SCLK_HALF = 2, TIMEOUT_CYC = 300, SYNC_ONES = 128 and the default RESET_CFG. A 300-cycle timeout makes the expiry path and the zero-filled reply cheap to reach. The full 129-bit resynchronisation pattern also fits in a few hundred cycles, so its exact bit count and closing zero are checked at full size. A bit-level slave model on SCLK and CS records every SDI bit and serves SDO from a preset word. This lets the bench compare bit counts, bit order and chip-select periods directly, including a long stall with CS low while the bridge waits for conv_ready.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_WRITE, K_READ, K_CAL, K_CONV, K_MULTI,
        K_SYNC, K_RESET, K_RAWW, K_RAWR
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [7:0] spi_cmd;
        logic [1:0] n_args;
    } cmd_dec_t;

    typedef enum logic [2:0] {S_IDLE, S_ARGS, S_XFER, S_WAIT, S_SEND} fsm_e;

    localparam logic [2:0] RC_OFFSET = 3'd1;
    localparam logic [2:0] RC_GAIN   = 3'd2;
    localparam logic [2:0] RC_CONFIG = 3'd3;
    localparam logic [2:0] RC_FIFO   = 3'd4;
    localparam logic [2:0] RC_SETUP  = 3'd5;

    localparam logic [7:0] C_MULTI = 8'h1F;
    localparam logic [7:0] C_SYNC  = 8'h3F;
    localparam logic [7:0] C_RESET = 8'h4F;
    localparam logic [7:0] C_RAWR  = 8'hEF;
    localparam logic [7:0] C_RAWW  = 8'hFF;
    localparam logic [7:0] C_CFG_WRITE  = 8'h03;
    localparam logic [7:0] C_CONV_SETUP1 = 8'h80;

    function automatic cmd_dec_t decode_cmd(input logic [7:0] b);
        cmd_dec_t d;
        d.kind    = K_NONE;
        d.spi_cmd = b;
        d.n_args  = 2'd0;
        if (b == C_MULTI) begin
            d.kind = K_MULTI; d.spi_cmd = C_CONV_SETUP1; d.n_args = 2'd1;
        end else if (b == C_SYNC) begin
            d.kind = K_SYNC;
        end else if (b == C_RESET) begin
            d.kind = K_RESET; d.spi_cmd = C_CFG_WRITE;
        end else if (b == C_RAWR) begin
            d.kind = K_RAWR;
        end else if (b == C_RAWW) begin
            d.kind = K_RAWW; d.n_args = 2'd1;
        end else if (b[7]) begin
            case (b[2:0])
                3'd0:                   d.kind = K_CONV;
                3'd1, 3'd2, 3'd5, 3'd6: d.kind = K_CAL;
                default:                d.kind = K_NONE;
            endcase
        end else begin
            case (b[2:0])
                RC_OFFSET, RC_GAIN: d.kind = b[3] ? K_READ : K_WRITE;
                RC_CONFIG, RC_SETUP:
                    if (b[6:4] == 3'd0) d.kind = b[3] ? K_READ : K_WRITE;
                RC_FIFO:
                    if (b[6:4] == 3'd0 && b[3]) d.kind = K_READ;
                default: d.kind = K_NONE;
            endcase
            if (d.kind == K_WRITE) d.n_args = 2'd3;
        end
        return d;
    endfunction

endpackage

// File: rtl/slb_cmd_decode.sv
module slb_cmd_decode
    import slb_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_dec_t   dec
);
    always_comb dec = decode_cmd(cmd_byte);
endmodule

// File: rtl/slb_spi_shift.sv
module slb_spi_shift #(
    parameter int HALF = 4,
    parameter int NBW  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [31:0]    word,
    input  logic [NBW-1:0] nbits,
    input  logic           pad,
    input  logic           sdo,
    output logic           sclk,
    output logic           sdi,
    output logic           done,
    output logic [23:0]    rx
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    logic           busy;
    logic           pad_q;
    logic [DW-1:0]  div;
    logic [NBW-1:0] bitn, last;
    logic [31:0]    txw;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; sclk <= 1'b0; done <= 1'b0; pad_q <= 1'b0;
            div <= '0; bitn <= '0; last <= '0; txw <= '0; rx <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                sclk  <= 1'b0;
                div   <= '0;
                bitn  <= '0;
                last  <= nbits - NBW'(1);
                txw   <= word;
                pad_q <= pad;
            end else if (busy) begin
                if (div == DW'(HALF - 1)) begin
                    div <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                        rx   <= {rx[22:0], sdo};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == last) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitn <= bitn + NBW'(1);
                            txw  <= {txw[30:0], 1'b0};
                        end
                    end
                end else begin
                    div <= div + DW'(1);
                end
            end
        end
    end

    assign sdi = busy & (pad_q ? (bitn != last) : txw[31]);
endmodule

// File: rtl/serlink_spi_bridge.sv
module serlink_spi_bridge
    import slb_pkg::*;
#(
    parameter int          SCLK_HALF   = 4,
    parameter int          SYNC_ONES   = 128,
    parameter int          TIMEOUT_CYC = 1000000,
    parameter logic [23:0] RESET_CFG   = 24'h000080
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       tx_ready,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_sdi,
    input  logic       spi_sdo,
    input  logic       conv_ready,
    output logic       err_timeout
);
    localparam int MAXB = (SYNC_ONES + 1 > 32) ? SYNC_ONES + 1 : 32;
    localparam int NBW  = $clog2(MAXB + 1);
    localparam int TW   = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

    fsm_e       st;
    cmd_dec_t   dec;
    cmd_kind_e  kind_q;
    logic [7:0] cmd_q, rep_q;
    logic [23:0] data_q, res_q;
    logic [1:0] need_q, nout_q;
    logic [TW-1:0] tmo_q;
    logic       ph2_q, eng_start, eng_done;
    logic [23:0] eng_rx;
    logic [31:0] l_word;
    logic [NBW-1:0] l_nbits;
    logic       l_pad;

    slb_cmd_decode u_dec (.cmd_byte(rx_byte), .dec(dec));

    slb_spi_shift #(.HALF(SCLK_HALF), .NBW(NBW)) u_shift (
        .clk(clk), .rst(rst), .start(eng_start), .word(l_word),
        .nbits(l_nbits), .pad(l_pad), .sdo(spi_sdo),
        .sclk(spi_sclk), .sdi(spi_sdi), .done(eng_done), .rx(eng_rx)
    );

    // Shape of the SPI transaction for the command held in kind_q/ph2_q
    always_comb begin
        l_word  = '0;
        l_nbits = NBW'(8);
        l_pad   = 1'b0;
        case (kind_q)
            K_WRITE: begin l_word = {cmd_q, data_q};    l_nbits = NBW'(32); end
            K_RESET: begin l_word = {cmd_q, RESET_CFG}; l_nbits = NBW'(32); end
            K_READ:  begin l_word = {cmd_q, 24'h0};     l_nbits = NBW'(32); end
            K_CAL:   l_word = {cmd_q, 24'h0};
            K_CONV, K_MULTI:
                if (ph2_q) l_nbits = NBW'(24);
                else       l_word  = {cmd_q, 24'h0};
            K_SYNC:  begin l_pad = 1'b1; l_nbits = NBW'(SYNC_ONES + 1); end
            K_RAWW:  l_word = {data_q[23:16], 24'h0};
            default: ;
        endcase
    end

    assign rx_ready = (st == S_IDLE) || (st == S_ARGS);
    assign tx_valid = (st == S_SEND);
    assign tx_byte  = res_q[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; kind_q <= K_NONE; cmd_q <= '0; rep_q <= '0;
            data_q <= '0; res_q <= '0; need_q <= '0; nout_q <= '0;
            tmo_q <= '0; ph2_q <= 1'b0; eng_start <= 1'b0;
            spi_cs_n <= 1'b1; err_timeout <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            case (st)
                S_IDLE: if (rx_valid) begin
                    err_timeout <= 1'b0;
                    kind_q <= dec.kind;
                    cmd_q  <= dec.spi_cmd;
                    need_q <= dec.n_args;
                    ph2_q  <= 1'b0;
                    rep_q  <= '0;
                    if (dec.kind != K_NONE) begin
                        if (dec.n_args != 2'd0) begin
                            st <= S_ARGS;
                        end else begin
                            spi_cs_n <= 1'b0; eng_start <= 1'b1; st <= S_XFER;
                        end
                    end
                end
                S_ARGS: if (rx_valid) begin
                    data_q <= {rx_byte, data_q[23:8]};
                    need_q <= need_q - 2'd1;
                    if (need_q == 2'd1) begin
                        if (kind_q == K_MULTI && rx_byte == 8'h00) begin
                            st <= S_IDLE;
                        end else begin
                            rep_q <= rx_byte - 8'd1;
                            spi_cs_n <= 1'b0; eng_start <= 1'b1; st <= S_XFER;
                        end
                    end
                end
                S_XFER: if (eng_done) begin
                    case (kind_q)
                        K_READ: begin
                            res_q <= eng_rx; nout_q <= 2'd3;
                            spi_cs_n <= 1'b1; st <= S_SEND;
                        end
                        K_RAWR: begin
                            res_q <= {16'h0, eng_rx[7:0]}; nout_q <= 2'd1;
                            spi_cs_n <= 1'b1; st <= S_SEND;
                        end
                        K_CONV, K_MULTI: begin
                            if (!ph2_q) begin
                                tmo_q <= '0; st <= S_WAIT;
                            end else begin
                                res_q <= eng_rx; nout_q <= 2'd3;
                                spi_cs_n <= 1'b1; st <= S_SEND;
                            end
                        end
                        default: begin
                            spi_cs_n <= 1'b1; st <= S_IDLE;
                        end
                    endcase
                end
                S_WAIT: begin
                    if (conv_ready) begin
                        ph2_q <= 1'b1; eng_start <= 1'b1; st <= S_XFER;
                    end else if (tmo_q == TW'(TIMEOUT_CYC - 1)) begin
                        err_timeout <= 1'b1; res_q <= '0; nout_q <= 2'd3;
                        spi_cs_n <= 1'b1; st <= S_SEND;
                    end else begin
                        tmo_q <= tmo_q + TW'(1);
                    end
                end
                S_SEND: if (tx_ready) begin
                    res_q  <= {8'h0, res_q[23:8]};
                    nout_q <= nout_q - 2'd1;
                    if (nout_q == 2'd1) begin
                        if (kind_q == K_MULTI && rep_q != 8'd0) begin
                            rep_q <= rep_q - 8'd1; ph2_q <= 1'b0;
                            spi_cs_n <= 1'b0; eng_start <= 1'b1; st <= S_XFER;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serlink_spi_bridge_chk.sv
module serlink_spi_bridge_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       tx_ready,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       spi_sdi,
    input logic       spi_sdo,
    input logic       conv_ready,
    input logic       err_timeout
);
    p_sclk_idle_r12: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    p_sdi_setup_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> $stable(spi_sdi));

    p_cs_high_on_accept_r12: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> spi_cs_n);

    p_tx_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    p_no_accept_while_tx_r13: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready);

    p_timeout_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> (tx_valid && tx_byte == 8'h00));
endmodule

bind serlink_spi_bridge serlink_spi_bridge_chk u_chk (.*);

// File: tb/serlink_spi_bridge_test.sv
`timescale 1ns/1ps
module serlink_spi_bridge_test;
    localparam logic [23:0] RCFG = 24'h000080;

    logic clk = 1'b0, rst = 1'b1;
    logic rx_valid = 1'b0, tx_ready = 1'b1, conv_ready = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic rx_ready, tx_valid, spi_cs_n, spi_sclk, spi_sdi, spi_sdo, err_timeout;
    logic [7:0] tx_byte;

    int checks = 0, fails = 0;
    logic [191:0] mosi_bits = '0;
    int mosi_n = 0, sb = 0, csf = 0, bad_clk = 0, ngot = 0;
    logic [7:0] got [0:15];
    logic [31:0] slave_word = '0;

    always #2 clk = ~clk;

    serlink_spi_bridge #(.SCLK_HALF(2), .SYNC_ONES(128), .TIMEOUT_CYC(300),
                         .RESET_CFG(RCFG)) uut (.*);

    // converter slave model
    assign spi_sdo = (sb < 32) ? slave_word[31 - sb] : 1'b0;
    always @(negedge spi_cs_n) begin csf++; sb = 0; end
    always @(posedge spi_sclk) begin
        if (spi_cs_n) bad_clk++;
        else begin
            mosi_bits = {mosi_bits[190:0], spi_sdi};
            mosi_n++; sb++;
        end
    end
    always @(negedge clk)
        if (tx_valid && tx_ready && ngot < 16) begin got[ngot] = tx_byte; ngot++; end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        mosi_bits = '0; mosi_n = 0; csf = 0; ngot = 0; bad_clk = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(spi_cs_n && !spi_sclk && !tx_valid && !err_timeout && rx_ready, "R12 reset state",
            {spi_cs_n, spi_sclk, tx_valid, err_timeout, rx_ready}, 5'b10001);
    endtask

    task automatic t_write();
        clear_mon();
        send_byte(8'h12); send_byte(8'h56); send_byte(8'h34); send_byte(8'h12);
        wait_idle();
        chk(mosi_n == 32 && mosi_bits[31:0] == 32'h12123456, "R1 write frame",
            mosi_bits[31:0], 32'h12123456);
        chk(csf == 1 && bad_clk == 0, "R12 single CS period", csf, 1);
    endtask

    task automatic t_read();
        logic [7:0] hold;
        clear_mon();
        slave_word = 32'h00ABCDEF;
        @(posedge clk); #1 tx_ready = 1'b0;
        send_byte(8'h29);
        @(negedge clk);
        while (!tx_valid) @(negedge clk);
        hold = tx_byte;
        repeat (5) @(negedge clk);
        chk(tx_valid && tx_byte == hold && hold == 8'hEF, "R13 hold under backpressure", tx_byte, 8'hEF);
        @(posedge clk); #1 tx_ready = 1'b1;
        wait_idle();
        chk(ngot == 3 && got[0] == 8'hEF && got[1] == 8'hCD && got[2] == 8'hAB, "R2 read bytes",
            {got[0], got[1], got[2]}, 24'hEFCDAB);
        chk(mosi_n == 32 && mosi_bits[31:24] == 8'h29, "R2 read command", mosi_bits[31:24], 8'h29);
    endtask

    task automatic t_fifo();
        clear_mon();
        slave_word = 32'h00102030;
        send_byte(8'h0C);
        wait_idle();
        chk(ngot == 3 && got[0] == 8'h30 && got[2] == 8'h10 && mosi_bits[31:24] == 8'h0C,
            "R3 fifo read", {got[0], got[2]}, 16'h3010);
    endtask

    task automatic t_cal();
        clear_mon();
        send_byte(8'hA9);
        wait_idle();
        chk(mosi_n == 8 && mosi_bits[7:0] == 8'hA9 && ngot == 0, "R4 self-offset cal", mosi_bits[7:0], 8'hA9);
        clear_mon();
        send_byte(8'hB6);
        wait_idle();
        chk(mosi_n == 8 && mosi_bits[7:0] == 8'hB6 && ngot == 0, "R4 system-gain cal", mosi_bits[7:0], 8'hB6);
    endtask

    task automatic t_conv();
        clear_mon();
        conv_ready = 1'b0;
        slave_word = 32'h00123456;
        send_byte(8'h88);
        repeat (60) @(negedge clk);
        chk(mosi_n == 8 && mosi_bits[7:0] == 8'h88 && !spi_cs_n, "R5 waiting with CS low",
            mosi_n, 8);
        conv_ready = 1'b1;
        wait_idle();
        conv_ready = 1'b0;
        chk(ngot == 3 && got[0] == 8'h56 && got[1] == 8'h34 && got[2] == 8'h12 && mosi_n == 32 && csf == 1,
            "R5 conversion result", {got[0], got[1], got[2]}, 24'h563412);
        chk(!err_timeout, "R6 no error on success", err_timeout, 0);
    endtask

    task automatic t_timeout();
        clear_mon();
        conv_ready = 1'b0;
        send_byte(8'h80);
        wait_idle();
        chk(ngot == 3 && got[0] == 8'h00 && got[1] == 8'h00 && got[2] == 8'h00 && err_timeout,
            "R6 timeout zeros and flag", {err_timeout, got[0], got[1], got[2]}, 25'h1000000);
        send_byte(8'h07);
        wait_idle();
        chk(!err_timeout, "R6 flag cleared by next command", err_timeout, 0);
    endtask

    task automatic t_sync();
        clear_mon();
        send_byte(8'h3F);
        wait_idle();
        chk(mosi_n == 129 && mosi_bits[128:1] == {128{1'b1}} && !mosi_bits[0] && csf == 1,
            "R7 resync pattern", mosi_n, 129);
    endtask

    task automatic t_rst_cmd();
        clear_mon();
        send_byte(8'h4F);
        wait_idle();
        chk(mosi_n == 32 && mosi_bits[31:0] == {8'h03, RCFG}, "R8 restore defaults",
            mosi_bits[31:0], {8'h03, RCFG});
    endtask

    task automatic t_multi();
        clear_mon();
        conv_ready = 1'b1;
        slave_word = 32'h00A1B2C3;
        send_byte(8'h1F); send_byte(8'h02);
        wait_idle();
        chk(ngot == 6 && got[3] == 8'hC3 && got[4] == 8'hB2 && got[5] == 8'hA1, "R9 two conversions",
            ngot, 6);
        chk(csf == 2 && mosi_n == 64 && mosi_bits[63:56] == 8'h80 && mosi_bits[31:24] == 8'h80,
            "R9 setup-1 commands", csf, 2);
        clear_mon();
        send_byte(8'h1F); send_byte(8'h00);
        wait_idle();
        conv_ready = 1'b0;
        chk(csf == 0 && ngot == 0 && mosi_n == 0, "R9 zero count", csf, 0);
    endtask

    task automatic t_raw();
        clear_mon();
        send_byte(8'hFF); send_byte(8'h5A);
        wait_idle();
        chk(mosi_n == 8 && mosi_bits[7:0] == 8'h5A && ngot == 0, "R10 raw write", mosi_bits[7:0], 8'h5A);
        clear_mon();
        slave_word = 32'hC3000000;
        send_byte(8'hEF);
        wait_idle();
        chk(ngot == 1 && got[0] == 8'hC3, "R10 raw read", got[0], 8'hC3);
    endtask

    task automatic t_ignored();
        clear_mon();
        send_byte(8'h07); wait_idle();
        send_byte(8'h84); wait_idle();
        send_byte(8'h13); wait_idle();
        send_byte(8'h34); wait_idle();
        chk(mosi_n == 0 && csf == 0 && ngot == 0 && bad_clk == 0, "R11 ignored codes (R3 decode)",
            mosi_n + csf + ngot, 0);
        chk(rx_ready && spi_cs_n, "R11 still accepting", rx_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_fifo();
        t_cal();
        t_conv();
        t_timeout();
        t_sync();
        t_rst_cmd();
        t_multi();
        t_raw();
        t_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule